// File: doc/BRIEF.md
# Linked-List Command Fetch Engine

This block walks a chain of command nodes in main memory and feeds their contents to a command consumer. Each node begins with one header word. The header carries two fields: a payload word count, and the byte address of the following node. The payload words sit directly after the header. The engine reads the header and sends each payload word in turn to a valid/ready sink. Only after the last payload word has been taken does it go to the next node. The walk ends as soon as the current node address has its end flag set.

During the walk the engine keeps a running estimate of the cost of processing the list, in cycles. A list might be circular by mistake. To guard against this, the engine counts the nodes it has visited. Once the count passes a threshold, it writes the end flag back into the header of every further node it visits. When the walk returns to a node it has already marked, the walk stops.

The memory port carries one request at a time and holds it until a single response pulse comes back. A write uses the same port and completes on the same pulse.

Top module: `cmd_list_walker`

## Requirements
- R1: After reset, busy_o, done_o, cmd_valid_o and mem_req_o are low and cycles_o is 0.
- R2: A pulse on start_i while idle starts a walk at start_addr_i. Only address bits 20:0 select memory, and the word index presented on mem_addr_o is bits 20:2. In a header word, bits 31:24 give the payload length and bits 23:0 give the next node address. Each header and each payload word is fetched exactly once per visit.
- R3: For a node of length L, the L words that follow its header are sent in address order on cmd_data_o. Each word stays valid and unchanged until cmd_ready_i accepts it.
- R4: No memory request is issued while a payload word is waiting for the sink. The next header is read only after the whole payload has been accepted.
- R5: A node of length 0 produces no payload. The walk moves straight on to its next address.
- R6: A walk ends when bit 23 of the current node address is set, and this includes the start address. An end flag on the start address means no memory access at all. At the end, done_o pulses high for exactly one cycle, and busy_o is low during that cycle.
- R7: cycles_o is cleared when a walk starts. It then gains 10 for every node visited, plus 5+L for each node whose length L is not 0. It holds its value after the walk until the next start.
- R8: Visited nodes are numbered from 0. After a node numbered above LOOP_THRESH has been processed, its header word is written back with bit 23 set. A circular list therefore ends one visit after it comes back to a marked node. No other memory word is ever written.
- R9: start_i is ignored while busy_o is high.
- R10: An outstanding memory request keeps its address and direction stable until mem_rvalid_i answers it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a walk (taken only when idle) |
| start_addr_i | input | LINK_W | Byte address of the first node |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle pulse when the walk ends |
| cycles_o | output | CYC_W | Cost estimate accumulated for the walk |
| mem_req_o | output | 1 | Memory request, held until the response |
| mem_we_o | output | 1 | Request is a header write-back |
| mem_addr_o | output | MEM_AW-2 | Word index of the request |
| mem_wdata_o | output | DATA_W | Write data (marked header) |
| mem_rvalid_i | input | 1 | Response or write completion pulse |
| mem_rdata_i | input | DATA_W | Read data |
| cmd_valid_o | output | 1 | Payload word available |
| cmd_ready_i | input | 1 | Sink takes the word |
| cmd_data_o | output | DATA_W | Payload word |

## Verification
Suppose the header index or the next-node register is wrong. The sink then receives the wrong payload sequence, or the number of memory responses differs from the count the node structure implies; both are visible by the end of the node that went wrong. A slip in the loop counter shows up as extra or missing header write-backs in a memory image compared after a circular walk. A cost error shows up in cycles_o as soon as done_o pulses. Handshake slips, such as a word dropped while the sink stalls or a request that changes while it is pending, are caught on the cycle they occur.

// File: rtl/cmd_list_walker_pkg.sv
package cmd_list_walker_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_HDR,
    ST_PRD,
    ST_POUT,
    ST_LINK,
    ST_MARK
  } walk_state_e;
endpackage

// File: rtl/cmd_walk_cost.sv
module cmd_walk_cost #(
  parameter int CYC_W     = 32,
  parameter int LEN_W     = 8,
  parameter int NODE_COST = 10,
  parameter int PAY_COST  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             add_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [CYC_W-1:0] total_o
);
  logic [CYC_W-1:0] total_q;
  logic [CYC_W-1:0] inc;

  assign inc = CYC_W'(NODE_COST) +
               ((len_i != '0) ? (CYC_W'(PAY_COST) + CYC_W'(len_i)) : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    total_q <= '0;
    else if (clr_i) total_q <= '0;
    else if (add_i) total_q <= total_q + inc;
  end

  assign total_o = total_q;
endmodule

// File: rtl/cmd_walk_loop_guard.sv
module cmd_walk_loop_guard #(
  parameter int LOOP_THRESH = 8192
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  output logic mark_o
);
  localparam int CNT_W = $clog2(LOOP_THRESH + 2) + 1;
  localparam logic [CNT_W-1:0] SAT = CNT_W'(LOOP_THRESH + 1);

  // saturates one past the threshold: index of current node, clamped
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (step_i && cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
  end

  assign mark_o = (cnt_q == SAT);
endmodule

// File: rtl/cmd_list_walker.sv
module cmd_list_walker
  import cmd_list_walker_pkg::*;
#(
  parameter int LINK_W      = 24,
  parameter int MEM_AW      = 21,
  parameter int DATA_W      = 32,
  parameter int LEN_W       = 8,
  parameter int LOOP_THRESH = 8192,
  parameter int CYC_W       = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [LINK_W-1:0]   start_addr_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [CYC_W-1:0]    cycles_o,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [MEM_AW-3:0]   mem_addr_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  input  logic                mem_rvalid_i,
  input  logic [DATA_W-1:0]   mem_rdata_i,
  output logic                cmd_valid_o,
  input  logic                cmd_ready_i,
  output logic [DATA_W-1:0]   cmd_data_o
);
  localparam int WORD_AW = MEM_AW - 2;
  localparam int END_BIT = LINK_W - 1;

  walk_state_e        state_q;
  logic               end_q;
  logic [WORD_AW-1:0] idx_q;
  logic [WORD_AW-1:0] hdr_idx_q;
  logic [WORD_AW-1:0] ptr_q;
  logic [LEN_W-1:0]   rem_q;
  logic [DATA_W-1:0]  hdr_q;
  logic [DATA_W-1:0]  data_q;
  logic               done_q;

  logic [LEN_W-1:0]   hdr_len;
  logic [DATA_W-1:0]  end_mask;
  logic               launch;
  logic               cost_add;
  logic               mark_now;
  logic               unused_addr_bits;

  assign hdr_len  = mem_rdata_i[DATA_W-1 -: LEN_W];
  assign end_mask = DATA_W'(1) << END_BIT;
  assign launch   = (state_q == ST_IDLE) && start_i;
  assign cost_add = (state_q == ST_HDR) && mem_rvalid_i;
  assign unused_addr_bits = ^{start_addr_i[1:0], start_addr_i[LINK_W-2:MEM_AW]};

  cmd_walk_cost #(
    .CYC_W (CYC_W),
    .LEN_W (LEN_W)
  ) u_cost (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (launch),
    .add_i   (cost_add),
    .len_i   (hdr_len),
    .total_o (cycles_o)
  );

  cmd_walk_loop_guard #(
    .LOOP_THRESH (LOOP_THRESH)
  ) u_guard (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (launch),
    .step_i (state_q == ST_LINK),
    .mark_o (mark_now)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      end_q     <= 1'b0;
      idx_q     <= '0;
      hdr_idx_q <= '0;
      ptr_q     <= '0;
      rem_q     <= '0;
      hdr_q     <= '0;
      data_q    <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          end_q   <= start_addr_i[END_BIT];
          idx_q   <= start_addr_i[MEM_AW-1:2];
          state_q <= ST_CHECK;
        end
        ST_CHECK: begin
          if (end_q) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            hdr_idx_q <= idx_q;
            state_q   <= ST_HDR;
          end
        end
        ST_HDR: if (mem_rvalid_i) begin
          hdr_q   <= mem_rdata_i;
          end_q   <= mem_rdata_i[END_BIT];
          idx_q   <= mem_rdata_i[MEM_AW-1:2];
          rem_q   <= hdr_len;
          ptr_q   <= hdr_idx_q + 1'b1;
          state_q <= (hdr_len != '0) ? ST_PRD : ST_LINK;
        end
        ST_PRD: if (mem_rvalid_i) begin
          data_q  <= mem_rdata_i;
          state_q <= ST_POUT;
        end
        ST_POUT: if (cmd_ready_i) begin
          ptr_q   <= ptr_q + 1'b1;
          rem_q   <= rem_q - 1'b1;
          state_q <= (rem_q == LEN_W'(1)) ? ST_LINK : ST_PRD;
        end
        ST_LINK: state_q <= mark_now ? ST_MARK : ST_CHECK;
        ST_MARK: if (mem_rvalid_i) state_q <= ST_CHECK;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = (state_q == ST_HDR) || (state_q == ST_PRD) || (state_q == ST_MARK);
    mem_we_o    = (state_q == ST_MARK);
    mem_addr_o  = (state_q == ST_PRD) ? ptr_q : hdr_idx_q;
    mem_wdata_o = hdr_q | end_mask;
    cmd_valid_o = (state_q == ST_POUT);
    cmd_data_o  = data_q;
    busy_o      = (state_q != ST_IDLE);
    done_o      = done_q;
  end
endmodule

// File: rtl/cmd_list_walker_chk.sv
module cmd_list_walker_chk #(
  parameter int CYC_W   = 32,
  parameter int DATA_W  = 32,
  parameter int WORD_AW = 19
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               busy_o,
  input logic               done_o,
  input logic [CYC_W-1:0]   cycles_o,
  input logic               mem_req_o,
  input logic               mem_we_o,
  input logic [WORD_AW-1:0] mem_addr_o,
  input logic               wr_flag_i,
  input logic               mem_rvalid_i,
  input logic               cmd_valid_o,
  input logic               cmd_ready_i,
  input logic [DATA_W-1:0]  cmd_data_o
);
  assert_pay_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_data_o));

  assert_no_fetch_in_pay_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> !mem_req_o);

  assert_done_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_cost_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> $stable(cycles_o));

  assert_mark_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> wr_flag_i);

  assert_busy_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o && mem_req_o |=> busy_o);

  assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));
endmodule

bind cmd_list_walker cmd_list_walker_chk #(
  .CYC_W   (CYC_W),
  .DATA_W  (DATA_W),
  .WORD_AW (WORD_AW)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .cycles_o     (cycles_o),
  .mem_req_o    (mem_req_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .wr_flag_i    (mem_wdata_o[LINK_W-1]),
  .mem_rvalid_i (mem_rvalid_i),
  .cmd_valid_o  (cmd_valid_o),
  .cmd_ready_i  (cmd_ready_i),
  .cmd_data_o   (cmd_data_o)
);

// File: tb/cmd_list_walker_tb.sv
module cmd_list_walker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TH = 20;
  localparam int MW = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] start_addr = '0;
  logic        busy, done;
  logic [31:0] cycles;
  logic        mem_req, mem_we;
  logic [18:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        cmd_valid;
  logic        cmd_ready = 1'b0;
  logic [31:0] cmd_data;

  logic [31:0] mem     [0:MW-1];
  logic [31:0] ref_mem [0:MW-1];
  logic [31:0] exp_pay [0:4095];
  logic [31:0] got_pay [0:4095];
  int exp_n, got_n, exp_acc, n_resp;
  logic [31:0] exp_cyc;
  int checks = 0, errors = 0;
  int r4_viol = 0, r10_viol = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_list_walker #(.LOOP_THRESH(TH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_addr_i(start_addr),
    .busy_o(busy), .done_o(done), .cycles_o(cycles),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_data_o(cmd_data));

  // memory model and sink, both acting on the falling edge
  initial begin
    bit pend;
    int lat;
    logic [18:0] h_addr;
    logic h_we;
    pend = 0; lat = 0; h_addr = '0; h_we = 0; n_resp = 0;
    forever begin
      @(negedge clk);
      cmd_ready = ($urandom % 4) != 0;
      if (cmd_valid && cmd_ready) begin
        got_pay[got_n] = cmd_data;
        got_n++;
      end
      if (cmd_valid && mem_req) r4_viol++;
      if (mem_rvalid) mem_rvalid = 1'b0;
      else if (mem_req) begin
        if (!pend) begin
          pend = 1; lat = $urandom % 3; h_addr = mem_addr; h_we = mem_we;
        end else if (mem_addr != h_addr || mem_we != h_we) r10_viol++;
        if (lat == 0) begin
          if (mem_we) mem[mem_addr[9:0]] = mem_wdata;
          else mem_rdata = mem[mem_addr[9:0]];
          mem_rvalid = 1'b1;
          pend = 0;
          n_resp++;
        end else lat--;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic put(input int idx, input logic [31:0] v);
    mem[idx] = v;
    ref_mem[idx] = v;
  endtask

  task automatic fill_random();
    for (int i = 0; i < MW; i++) put(i, $urandom);
  endtask

  // reference walk on the bench copy of memory
  function automatic void model(input logic [23:0] s);
    logic [23:0] a;
    int cnt;
    a = s; cnt = 0; exp_n = 0; exp_cyc = 0; exp_acc = 0;
    while (!a[23] && cnt < 100000) begin
      logic [9:0] idx;
      logic [31:0] h;
      int len;
      idx = a[11:2];
      h = ref_mem[idx];
      len = int'(h[31:24]);
      a = h[23:0];
      exp_cyc += 10;
      exp_acc += 1 + len;
      if (len != 0) exp_cyc += 32'(5 + len);
      for (int i = 0; i < len; i++) begin
        exp_pay[exp_n] = ref_mem[10'(idx + 10'(1 + i))];
        exp_n++;
      end
      if (cnt > TH) begin
        ref_mem[idx] = ref_mem[idx] | 32'h0080_0000;
        exp_acc++;
      end
      cnt++;
    end
  endfunction

  task automatic run_walk(input logic [23:0] s, input bit poke, input string tag);
    int wd, resp0, pay_bad, mem_bad;
    model(s);
    got_n = 0;
    resp0 = n_resp;
    @(negedge clk); start = 1'b1; start_addr = s;
    @(negedge clk); start = 1'b0; start_addr = 24'($urandom);
    if (poke) begin
      repeat (6) @(negedge clk);
      chk(busy, "R9", {tag, " busy before poke"}, 32'(busy), 1);
      start = 1'b1; start_addr = 24'h000200;
      @(negedge clk); start = 1'b0;
    end
    wd = 0;
    while (!done && wd < 60000) begin
      @(negedge clk);
      wd++;
    end
    chk(done, "R6", {tag, " walk finished"}, 32'(done), 1);
    chk(!busy, "R6", {tag, " idle at done"}, 32'(busy), 0);
    chk(cycles == exp_cyc, "R7", {tag, " cost"}, cycles, exp_cyc);
    chk(got_n == exp_n, "R3", {tag, " payload count"}, 32'(got_n), 32'(exp_n));
    pay_bad = 0;
    for (int i = 0; i < exp_n && i < got_n; i++)
      if (got_pay[i] !== exp_pay[i]) pay_bad++;
    chk(pay_bad == 0, "R3", {tag, " payload order"}, 32'(pay_bad), 0);
    chk((n_resp - resp0) == exp_acc, "R2", {tag, " memory accesses"},
        32'(n_resp - resp0), 32'(exp_acc));
    mem_bad = 0;
    for (int i = 0; i < MW; i++) if (mem[i] !== ref_mem[i]) mem_bad++;
    chk(mem_bad == 0, "R8", {tag, " memory image"}, 32'(mem_bad), 0);
    @(negedge clk);
    chk(!done, "R6", {tag, " done one cycle"}, 32'(done), 0);
  endtask

  // chain of n nodes in distinct 16-word slots; random high address bits
  task automatic build_chain(input int n, input int first, input int min_len,
                             output logic [23:0] s);
    for (int k = 0; k < n; k++) begin
      int base, nbase, len;
      logic [23:0] link;
      base  = ((first + k * 7) % 60) * 16;
      nbase = ((first + (k + 1) * 7) % 60) * 16;
      len   = min_len + int'($urandom % (13 - min_len));
      if (k == n - 1) link = 24'h80_0000 | 24'($urandom % 24'h7f_ffff);
      else link = {1'b0, 2'($urandom), 21'(nbase * 4)};
      put(base, {8'(len), link});
    end
    s = {1'b0, 2'($urandom), 21'(((first % 60) * 16) * 4)};
  endtask

  initial begin
    logic [23:0] s;
    void'($urandom(32'h5eed_0042));
    got_n = 0;
    fill_random();
    repeat (3) @(negedge clk);
    chk(!busy && !done && !cmd_valid && !mem_req, "R1", "reset outputs",
        {28'd0, busy, done, cmd_valid, mem_req}, 0);
    chk(cycles == 0, "R1", "reset cost", cycles, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R5: single zero-length node
    put(16, {8'd0, 24'h80_1234});
    run_walk(24'h000040, 0, "R5 empty node");
    chk(got_n == 0, "R5", "no payload for zero length", 32'(got_n), 0);

    // R7: longest node, cost 10+5+255
    put(768, {8'd255, 24'h80_0000});
    run_walk(24'h000C00, 0, "R7 max length");
    chk(cycles == 32'd270, "R7", "max length cost", cycles, 270);

    // R6: end flag on the start address, no memory access
    begin
      int r0;
      r0 = n_resp;
      run_walk(24'h80_0010, 0, "R6 immediate end");
      chk(cycles == 0, "R6", "cost cleared, no node", cycles, 0);
      chk(n_resp == r0, "R6", "no memory access", 32'(n_resp - r0), 0);
    end

    // R2/R3/R7: random chains
    for (int t = 0; t < 8; t++) begin
      fill_random();
      build_chain(1 + int'($urandom % 12), int'($urandom % 60), 0, s);
      run_walk(s, 0, "R2 random chain");
    end

    // R9: start while busy has no effect
    fill_random();
    build_chain(10, 3, 4, s);
    run_walk(s, 1, "R9 start while busy");

    // R8: circular list of three nodes
    fill_random();
    put(900, {8'd2, 24'(910 * 4)});
    put(910, {8'd0, 24'h60_0000 | 24'(920 * 4)});
    put(920, {8'd3, 24'(900 * 4)});
    run_walk(24'(900 * 4), 0, "R8 circular list");
    chk(ref_mem[900][23] && mem[900][23], "R8", "loop header marked",
        mem[900], ref_mem[900]);

    // R8: straight list longer than the threshold
    fill_random();
    build_chain(30, 11, 0, s);
    run_walk(s, 0, "R8 long straight list");

    chk(r4_viol == 0, "R4", "memory request during payload", 32'(r4_viol), 0);
    chk(r10_viol == 0, "R10", "request changed while pending", 32'(r10_viol), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule